// File: doc/BRIEF.md
# Pseudo-static RAM WAIT and refresh arbiter

This block is the device-side sequencer that decides, cycle by cycle, whether a pseudo-static RAM can move a burst word or must hold the host off with WAIT. It sits between the synchronous host port and the internal refresh timer. Host bursts, internal refresh requests, the opening of a fresh row and the progress of a running burst all share one sequencer. One WAIT line reports every stall to the host: the first access latency, a collision with a refresh already running, and the pause when a burst runs off the end of a row.

A burst opens with a start strobe while chip enable is low and ends when chip enable rises. The column counter is an input. The beat at the last column of a row is followed by a row-open stall, and any refresh that was deferred during the burst runs inside that stall. The read/write flag is latched at burst start and steers each data beat onto a read-valid or a write-accept strobe. A configuration input chooses whether WAIT covers exactly the stalled cycles or leads them by one clock.

Top module: `psram_wait_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wait_o`, `ref_grant`, `rd_valid`, `wr_accept` and `row_open` are all 0.
- R2: A `burst_start` seen at a clock edge while idle with `ce_n` low and no refresh request is followed by exactly `ROW_OPEN_CYC` stalled cycles, then the first data beat.
- R3: `is_write` is sampled only with the accepted start. A burst started with 0 pulses `rd_valid` on each beat and a burst started with 1 pulses `wr_accept`. Later values of `is_write` have no effect, and the two strobes are never high together.
- R4: A refresh request seen while idle is granted from the next cycle. `ref_grant` then stays high for `REF_CYC` cycles, and WAIT is not raised when no access is waiting.
- R5: A burst started while a refresh is running is held with WAIT for the remaining refresh cycles and then `ROW_OPEN_CYC` more cycles. After that it transfers normally.
- R6: A data beat with `col_addr` equal to `ROW_WORDS`-1 while `ce_n` stays low is followed by `ROW_OPEN_CYC` stalled cycles in which `row_open` is 0. The burst then resumes.
- R7: A refresh requested during a burst is serviced at the next row crossing. The stall after the crossing beat is `REF_CYC` cycles with `ref_grant` high, then `ROW_OPEN_CYC` cycles of row opening.
- R8: `ref_grant` is never high in a cycle with a data beat. A refresh still pending when `ce_n` rises is granted from the next cycle for `REF_CYC` cycles.
- R9: With `wait_lead`=0, WAIT is high exactly in the stalled cycles of an access. With `wait_lead`=1, WAIT rises and falls one clock earlier: in the start cycle, and in the crossing beat.
- R10: While `ce_n` is high, `wait_o`, `rd_valid` and `wr_accept` are 0. On the clock after `ce_n` rises, the access state is idle, and the only activity that may continue is a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable; its rising edge ends a burst |
| burst_start | input | 1 | Burst start strobe, sampled with `ce_n` low |
| is_write | input | 1 | 1 = write burst, 0 = read burst; sampled with the start |
| col_addr | input | COL_W | Column of the current beat |
| ref_req | input | 1 | One-cycle refresh request from the internal timer |
| wait_lead | input | 1 | 0 = WAIT aligned with stalled cycles, 1 = one clock early |
| wait_o | output | 1 | Active-high WAIT to the host |
| ref_grant | output | 1 | High in every cycle an internal refresh runs |
| rd_valid | output | 1 | Read data valid for this beat |
| wr_accept | output | 1 | Write data accepted on this beat |
| row_open | output | 1 | A row is open and transferring |

## Verification
The bench builds the block with `ROW_WORDS`=8 and `COL_W`=3, so a row crossing comes after eight beats. With these values the crossing detector is the all-ones variant. `ROW_OPEN_CYC`=3 and `REF_CYC`=6 keep their defaults. These values let a single burst reach a crossing with and without a deferred refresh. Every stall length can then be counted against the requirement cycle by cycle, in both WAIT alignments.

// File: rtl/psram_wait_pkg.sv
package psram_wait_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REF  = 2'd1,
      ST_OPEN = 2'd2,
      ST_XFER = 2'd3
   } arb_state_t;

   function automatic int unsigned span_width(input int unsigned span);
      return (span < 2) ? 1 : $clog2(span + 1);
   endfunction

endpackage

// File: rtl/psram_row_edge.sv
module psram_row_edge #(
   parameter int unsigned ROW_WORDS = 128,
   parameter int unsigned COL_W     = 7
) (
   input  logic [COL_W-1:0] col_addr,
   output logic             at_last
);
   localparam int unsigned FULL_SPAN = 1 << COL_W;
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_WORDS - 1);

   if (ROW_WORDS < 2) begin : g_bad_rows
      $error("psram_row_edge: ROW_WORDS must be at least 2");
   end
   if (FULL_SPAN < ROW_WORDS) begin : g_bad_width
      $error("psram_row_edge: COL_W too narrow for ROW_WORDS");
   end

   if (FULL_SPAN == ROW_WORDS) begin : g_all_ones
      // row fills the counter exactly: last column is all ones
      assign at_last = &col_addr;
   end else begin : g_compare
      assign at_last = (col_addr == LAST_COL);
   end

endmodule

// File: rtl/psram_wait_seq.sv
module psram_wait_seq
   import psram_wait_pkg::*;
#(
   parameter int unsigned ROW_OPEN_CYC = 3,
   parameter int unsigned REF_CYC      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic burst_start,
   input  logic is_write,
   input  logic ref_req,
   input  logic at_last,
   output logic stall_cur,
   output logic stall_nxt,
   output logic ref_busy,
   output logic in_xfer,
   output logic dir_wr
);
   localparam int unsigned CNT_W = span_width(ROW_OPEN_CYC + REF_CYC);
   localparam logic [CNT_W-1:0] OPEN_LD  = CNT_W'(ROW_OPEN_CYC - 1);
   localparam logic [CNT_W-1:0] REF_LD   = CNT_W'(REF_CYC - 1);
   localparam logic [CNT_W-1:0] BOTH_LD  = CNT_W'(REF_CYC + ROW_OPEN_CYC - 1);
   localparam logic [CNT_W-1:0] OPEN_CNT = CNT_W'(ROW_OPEN_CYC);

   if (ROW_OPEN_CYC < 1) begin : g_bad_open
      $error("psram_wait_seq: ROW_OPEN_CYC must be at least 1");
   end
   if (REF_CYC < 1) begin : g_bad_ref
      $error("psram_wait_seq: REF_CYC must be at least 1");
   end

   arb_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             accp_q, accp_d;
   logic             refp_q, refp_d;
   logic             dir_q, dir_d;
   logic             start_ok;
   logic             ref_in_open;

   assign start_ok    = !ce_n && burst_start;
   assign ref_in_open = (st_q == ST_OPEN) && (cnt_q >= OPEN_CNT);

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      accp_d = accp_q;
      refp_d = refp_q;
      dir_d  = dir_q;
      unique case (st_q)
         ST_IDLE: begin
            accp_d = 1'b0;
            refp_d = 1'b0;
            if (start_ok) dir_d = is_write;
            if (ref_req) begin
               st_d   = ST_REF;
               cnt_d  = REF_LD;
               accp_d = start_ok;
            end else if (start_ok) begin
               st_d  = ST_OPEN;
               cnt_d = OPEN_LD;
            end
         end
         ST_REF: begin
            if (ce_n) begin
               accp_d = 1'b0;
            end else if (burst_start && !accp_q) begin
               accp_d = 1'b1;
               dir_d  = is_write;
            end
            if (cnt_q == '0) begin
               if (accp_d) begin
                  st_d  = ST_OPEN;
                  cnt_d = OPEN_LD;
               end else begin
                  st_d = ST_IDLE;
               end
               accp_d = 1'b0;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_OPEN: begin
            if (ce_n) begin
               refp_d = 1'b0;
               if (cnt_q > OPEN_CNT) begin
                  // finish the refresh already under way
                  st_d  = ST_REF;
                  cnt_d = cnt_q - OPEN_CNT - 1'b1;
               end else if (refp_q || ref_req) begin
                  st_d  = ST_REF;
                  cnt_d = REF_LD;
               end else begin
                  st_d = ST_IDLE;
               end
            end else begin
               if (ref_req && !ref_in_open) refp_d = 1'b1;
               if (cnt_q == '0) st_d = ST_XFER;
               else             cnt_d = cnt_q - 1'b1;
            end
         end
         ST_XFER: begin
            if (ce_n) begin
               refp_d = 1'b0;
               if (refp_q || ref_req) begin
                  st_d  = ST_REF;
                  cnt_d = REF_LD;
               end else begin
                  st_d = ST_IDLE;
               end
            end else if (at_last) begin
               st_d   = ST_OPEN;
               cnt_d  = (refp_q || ref_req) ? BOTH_LD : OPEN_LD;
               refp_d = 1'b0;
            end else if (ref_req) begin
               refp_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         accp_q <= 1'b0;
         refp_q <= 1'b0;
         dir_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         accp_q <= accp_d;
         refp_q <= refp_d;
         dir_q  <= dir_d;
      end
   end

   assign stall_cur = (st_q == ST_OPEN) || ((st_q == ST_REF) && accp_q);
   assign stall_nxt = (st_d == ST_OPEN) || ((st_d == ST_REF) && accp_d);
   assign ref_busy  = (st_q == ST_REF) || ref_in_open;
   assign in_xfer   = (st_q == ST_XFER);
   assign dir_wr    = dir_q;

   // R2: an accepted start from idle stalls on the next cycle
   p_start_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start_ok && !ref_req) |=> (stall_cur && !in_xfer));

   // R6: the beat at the last column leads to a stall with no transfer
   p_cross_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && !ce_n && at_last) |=> (stall_cur && !in_xfer));

   // R10: after chip enable rises no access is in progress
   p_idle_after_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!stall_cur && !in_xfer));

endmodule

// File: rtl/psram_wait_drive.sv
module psram_wait_drive (
   input  logic ce_n,
   input  logic wait_lead,
   input  logic stall_cur,
   input  logic stall_nxt,
   input  logic in_xfer,
   input  logic dir_wr,
   output logic wait_o,
   output logic rd_valid,
   output logic wr_accept,
   output logic row_open
);
   logic stall_sel;

   // lead mode shows the stall the next edge will load
   assign stall_sel = wait_lead ? stall_nxt : stall_cur;
   assign wait_o    = !ce_n && stall_sel;
   assign rd_valid  = !ce_n && in_xfer && !dir_wr;
   assign wr_accept = !ce_n && in_xfer && dir_wr;
   assign row_open  = in_xfer;

endmodule

// File: rtl/psram_wait_arb.sv
module psram_wait_arb #(
   parameter int unsigned ROW_WORDS    = 128,
   parameter int unsigned COL_W        = 7,
   parameter int unsigned ROW_OPEN_CYC = 3,
   parameter int unsigned REF_CYC      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             burst_start,
   input  logic             is_write,
   input  logic [COL_W-1:0] col_addr,
   input  logic             ref_req,
   input  logic             wait_lead,
   output logic             wait_o,
   output logic             ref_grant,
   output logic             rd_valid,
   output logic             wr_accept,
   output logic             row_open
);
   logic at_last;
   logic stall_cur;
   logic stall_nxt;
   logic ref_busy;
   logic in_xfer;
   logic dir_wr;

   psram_row_edge #(
      .ROW_WORDS (ROW_WORDS),
      .COL_W     (COL_W)
   ) u_edge (
      .col_addr (col_addr),
      .at_last  (at_last)
   );

   psram_wait_seq #(
      .ROW_OPEN_CYC (ROW_OPEN_CYC),
      .REF_CYC      (REF_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce_n        (ce_n),
      .burst_start (burst_start),
      .is_write    (is_write),
      .ref_req     (ref_req),
      .at_last     (at_last),
      .stall_cur   (stall_cur),
      .stall_nxt   (stall_nxt),
      .ref_busy    (ref_busy),
      .in_xfer     (in_xfer),
      .dir_wr      (dir_wr)
   );

   psram_wait_drive u_drive (
      .ce_n      (ce_n),
      .wait_lead (wait_lead),
      .stall_cur (stall_cur),
      .stall_nxt (stall_nxt),
      .in_xfer   (in_xfer),
      .dir_wr    (dir_wr),
      .wait_o    (wait_o),
      .rd_valid  (rd_valid),
      .wr_accept (wr_accept),
      .row_open  (row_open)
   );

   assign ref_grant = ref_busy;

   // R8: refresh never shares a cycle with a data beat
   p_grant_no_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_grant |-> !(rd_valid || wr_accept));

   // R3: at most one beat strobe per cycle
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, wr_accept}));

   // R9: in lead mode WAIT predicts the stall of the following cycle
   p_wait_leads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wait_lead) && $past(!ce_n) && !ce_n)
         |-> ($past(wait_o) == stall_cur));

   // R10: WAIT is inactive whenever chip enable is high
   p_wait_off_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !wait_o);

endmodule

// File: tb/tb_psram_wait_arb.sv
module tb_psram_wait_arb;
   localparam int unsigned COL_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ce_n = 1'b1;
   logic             burst_start = 1'b0;
   logic             is_write = 1'b0;
   logic [COL_W-1:0] col_addr = '0;
   logic             ref_req = 1'b0;
   logic             wait_lead = 1'b0;
   logic             wait_o, ref_grant, rd_valid, wr_accept, row_open;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   psram_wait_arb #(
      .ROW_WORDS    (8),
      .COL_W        (COL_W),
      .ROW_OPEN_CYC (3),
      .REF_CYC      (6)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce_n        (ce_n),
      .burst_start (burst_start),
      .is_write    (is_write),
      .col_addr    (col_addr),
      .ref_req     (ref_req),
      .wait_lead   (wait_lead),
      .wait_o      (wait_o),
      .ref_grant   (ref_grant),
      .rd_valid    (rd_valid),
      .wr_accept   (wr_accept),
      .row_open    (row_open)
   );

   // driver: one cycle of stimulus plus the expected {wait,grant,rd,wr,row}
   task automatic cyc(input logic ce, input logic st, input logic wr,
                      input logic req, input int col, input logic [4:0] ex,
                      input string tag);
      @(negedge clk);
      ce_n        = ce;
      burst_start = st;
      is_write    = wr;
      ref_req     = req;
      col_addr    = COL_W'(col);
      exp_q.push_back(ex);
      tag_q.push_back(tag);
   endtask

   // monitor: compares outputs 2 ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [4:0] ex;
            logic [4:0] act;
            string      tg;
            ex  = exp_q.pop_front();
            tg  = tag_q.pop_front();
            act = {wait_o, ref_grant, rd_valid, wr_accept, row_open};
            checks++;
            if (act !== ex) begin
               errors++;
               $display("FAIL %s: {wait,grant,rd,wr,row} got %b expected %b at %0t",
                        tg, act, ex, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) cyc(1, 0, 0, 0, 0, 5'b00000, "R1 in reset");
      rst_n = 1'b1;
      cyc(1, 0, 0, 0, 0, 5'b00000, "R1 after reset");

      // R2/R3/R6 read burst, aligned WAIT
      wait_lead = 1'b0;
      cyc(0, 1, 0, 0, 0, 5'b00000, "R9 aligned start");
      repeat (3) cyc(0, 0, 1, 0, 0, 5'b10000, "R2 latency");
      for (int c = 0; c < 8; c++) cyc(0, 0, 1, 0, c, 5'b00101, "R3 read beat");
      repeat (3) cyc(0, 0, 0, 0, 0, 5'b10000, "R6 row opening");
      cyc(0, 0, 0, 0, 0, 5'b00101, "R6 resume");
      cyc(1, 0, 0, 0, 0, 5'b00001, "R10 ce high");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 idle");

      // R9 lead mode burst with crossing
      wait_lead = 1'b1;
      cyc(0, 1, 0, 0, 0, 5'b10000, "R9 lead start");
      repeat (2) cyc(0, 0, 0, 0, 0, 5'b10000, "R9 lead latency");
      cyc(0, 0, 0, 0, 0, 5'b00000, "R9 lead early release");
      for (int c = 0; c < 7; c++) cyc(0, 0, 0, 0, c, 5'b00101, "R9 lead beat");
      cyc(0, 0, 0, 0, 7, 5'b10101, "R9 lead crossing beat");
      repeat (2) cyc(0, 0, 0, 0, 0, 5'b10000, "R9 lead row opening");
      cyc(0, 0, 0, 0, 0, 5'b00000, "R9 lead early release");
      cyc(0, 0, 0, 0, 0, 5'b00101, "R9 lead resume");
      cyc(1, 0, 0, 0, 0, 5'b00001, "R10 ce high");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 idle");

      // R4 idle refresh
      wait_lead = 1'b0;
      cyc(1, 0, 0, 1, 0, 5'b00000, "R4 request");
      repeat (6) cyc(1, 0, 0, 0, 0, 5'b01000, "R4 grant");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R4 done");

      // R5 collision with write burst
      cyc(1, 0, 0, 1, 0, 5'b00000, "R5 request");
      cyc(0, 1, 1, 0, 0, 5'b01000, "R5 start during refresh");
      repeat (5) cyc(0, 0, 0, 0, 0, 5'b11000, "R5 wait on refresh");
      repeat (3) cyc(0, 0, 0, 0, 0, 5'b10000, "R5 row opening");
      cyc(0, 0, 0, 0, 0, 5'b00011, "R3 write latched");
      cyc(1, 0, 0, 0, 0, 5'b00001, "R10 ce high");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 idle");

      // R7 refresh deferred to the row crossing
      cyc(0, 1, 0, 0, 0, 5'b00000, "R7 start");
      repeat (3) cyc(0, 0, 0, 0, 0, 5'b10000, "R7 latency");
      cyc(0, 0, 0, 0, 0, 5'b00101, "R7 beat");
      cyc(0, 0, 0, 1, 1, 5'b00101, "R8 request during beat");
      for (int c = 2; c < 8; c++) cyc(0, 0, 0, 0, c, 5'b00101, "R8 no grant in beat");
      repeat (6) cyc(0, 0, 0, 0, 0, 5'b11000, "R7 refresh at crossing");
      repeat (3) cyc(0, 0, 0, 0, 0, 5'b10000, "R7 row opening");
      cyc(0, 0, 0, 0, 0, 5'b00101, "R7 resume");
      cyc(1, 0, 0, 0, 0, 5'b00001, "R10 ce high");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 idle");

      // R8 refresh pending at burst end
      cyc(0, 1, 0, 0, 0, 5'b00000, "R8 start");
      repeat (3) cyc(0, 0, 0, 0, 0, 5'b10000, "R8 latency");
      cyc(0, 0, 0, 1, 0, 5'b00101, "R8 request during beat");
      cyc(0, 0, 0, 0, 1, 5'b00101, "R8 beat");
      cyc(1, 0, 0, 0, 0, 5'b00001, "R8 ce high");
      repeat (6) cyc(1, 0, 0, 0, 0, 5'b01000, "R8 grant after burst");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R8 done");

      // R10 chip enable drops WAIT mid-latency, lead mode
      wait_lead = 1'b1;
      cyc(0, 1, 0, 0, 0, 5'b10000, "R10 start");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 wait gated");
      cyc(0, 0, 0, 0, 0, 5'b00000, "R10 back to idle");
      cyc(1, 0, 0, 0, 0, 5'b00000, "R10 idle");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule